// File: doc/BRIEF.md
# Single-Channel DMA Engine with Selectable Request Source

This block is one DMA channel. It copies a run of bytes from a source address to a destination address through a simple memory port, one unit at a time. Each unit is one read cycle followed by one write cycle. Software programs four registers: control, source, destination and byte count. It then sets the run bit. The control word chooses what paces the transfer: software alone, an external request line, or the request line of either of two serial ports. It also chooses the unit width, how each address moves after a unit, the transfer direction in the serial-port modes, and the bus mode. The bus modes are single, block, block with continuous bus hold, and demand.

When the count is used up, the channel goes idle. If enabled, it raises a level stop interrupt, which stays high until software clears the run bit. The count register can be read during a transfer to watch progress. Writing control with run clear stops the channel at once.

Top module: `dma_channel`

## Requirements
- R1: After reset all four registers read zero, the busy bit is 0, `irq` is 0 and `mem_req` is 0.
- R2: Register offsets are 0 control, 1 source, 2 destination and 3 count. The count register is 24 bits wide. Source, destination and count read back as written. Control stores bits 14:2 and bit 0. Bit 1 reads the busy status and ignores writes. Bits 31:15 read 0.
- R3: The width field, control[13:12], selects byte (0), halfword (1) or word (2), a step of 1, 2 or 4 bytes. `mem_size` carries that field. After each unit the count drops by the step, and it stops at zero when fewer bytes remain.
- R4: After each unit an address moves by the step. It increments when its control bits are clear and decrements when its decrement bit is set (destination bit 4, source bit 5). It stays put when its hold bit is set (destination bit 6, source bit 7). The hold bit wins over the decrement bit.
- R5: The mode field, control[3:2], selects the pacing source: 0 software (no request needed), 1 `ext_req`, 2 `uart0_req`, 3 `uart1_req`. Request lines that are not selected have no effect.
- R6: In modes 2 and 3, control bit 9 set means memory-to-port: the destination is held. Bit 9 clear means port-to-memory: the source is held. This holds whatever the hold bits say.
- R7: Each unit is a read cycle at the source address. It is followed in the very next cycle by a write cycle at the destination, carrying the data read.
- R8: Single mode is block (bit 10), continuous (bit 11) and demand (bit 14) all clear. In single mode, each rising edge of the selected request yields exactly one unit. An edge that arrives while a unit is in progress is remembered and served next.
- R9: In block mode, one request starts the transfer, and it runs until the count is zero. There is one idle bus cycle between units. With continuous set in a mode other than 0, the units follow back to back. Continuous has no effect without block or in mode 0.
- R10: Demand mode (bit 14 set, block and continuous clear) starts a unit only while the selected request is high. When the request drops, the channel waits with the count frozen.
- R11: The busy bit reads 1 from the cycle after the run write until the last write cycle. The count register shows the remaining bytes during the transfer.
- R12: With control bit 8 set, `irq` rises together with the end of busy after the last unit. It stays high until control is written with bit 0 clear. With bit 8 clear, `irq` stays low.
- R13: Setting run with width field 3 or a count of zero performs no memory access. The channel ends at once, and `irq` follows bit 8.
- R14: Writing control with bit 0 clear stops any transfer. It drops busy and `irq` the next cycle, and causes no further memory access. Zeroing all four registers returns the reset picture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| ext_req | input | 1 | External request line |
| uart0_req | input | 1 | Request from serial port 0 |
| uart1_req | input | 1 | Request from serial port 1 |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 write cycle, 0 read cycle |
| mem_size | output | 2 | Unit width, as in control[13:12] |
| mem_addr | output | ADDR_W | Byte address of the cycle |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, sampled at the end of the read cycle |
| irq | output | 1 | Stop interrupt, level |

## Verification
The bench attacks the count when the byte total is not a multiple of the unit. A design that underflowed would wrap and run on for millions of units. It checks the two serial-port modes with their hold bits clear. A design that trusted only those bits would walk the port address across memory. It sends a request pulse during a unit in single mode, which a design without a pending flag would lose, so the transfer would stall. It also checks the gap between units in block, continuous-with-software and continuous modes. Then it checks the idle drop of demand mode, width 3, zero count and an abort in mid-transfer. A wrong design would show stray memory cycles, a count that keeps moving, or `irq` stuck high.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_PORT0 = 2'd2,
        SRC_PORT1 = 2'd3
    } req_src_e;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_NONE = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_GAP   = 3'd4,
        ST_STOP  = 3'd5
    } dma_state_e;

    // control word, MSB first; bit 1 is a read-only status slot
    typedef struct packed {
        logic     demand;    // 14
        width_e   width;     // 13:12
        logic     cont;      // 11
        logic     block;     // 10
        logic     to_port;   // 9
        logic     irq_en;    // 8
        logic     src_hold;  // 7
        logic     dst_hold;  // 6
        logic     src_dec;   // 5
        logic     dst_dec;   // 4
        req_src_e mode;      // 3:2
        logic     status;    // 1
        logic     run;       // 0
    } dma_ctrl_t;

    localparam int unsigned CTRL_W = $bits(dma_ctrl_t);

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_SRC  = 2'd1;
    localparam logic [1:0] OFS_DST  = 2'd2;
    localparam logic [1:0] OFS_CNT  = 2'd3;

    function automatic logic [2:0] unit_bytes(input width_e w);
        case (w)
            W_BYTE:  return 3'd1;
            W_HALF:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
    import dma_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  req_src_e src,
    input  logic     active,
    input  logic     ext_req,
    input  logic     port0_req,
    input  logic     port1_req,
    input  logic     consume,
    output logic     req_level,
    output logic     req_pend
);
    localparam int unsigned NSRC = 4;

    typedef struct packed {
        logic prev;
        logic pend;
    } sel_t;

    sel_t q, d;
    logic [NSRC-1:0] lines;
    logic sel, rise;

    assign lines = {port1_req, port0_req, ext_req, 1'b1};
    assign sel   = lines[src];
    assign rise  = sel & ~q.prev;

    always_comb begin
        d      = q;
        d.prev = sel;
        // an edge seen during a unit is kept until a unit consumes it (R8)
        d.pend = active ? ((q.pend & ~consume) | rise) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_level = sel;
    assign req_pend  = (src == SRC_SOFT) | q.pend;
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    bytes,
    input  logic          dec,
    input  logic          hold,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (hold)     nxt = cur;
        else if (dec) nxt = cur - AW'(bytes);
        else          nxt = cur + AW'(bytes);
    end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ext_req,
    input  logic              uart0_req,
    input  logic              uart1_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        dma_state_e        st;
        dma_ctrl_t         ctrl;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              irq;
    } chan_t;

    chan_t q, d;

    logic [2:0]        step;
    logic              port_mode, src_hold_eff, dst_hold_eff;
    logic              cont_eff, demand_eff, single_mode;
    logic              busy, last_unit, go, consume;
    logic              req_level, req_pend;
    logic [ADDR_W-1:0] src_next, dst_next;
    dma_ctrl_t         wr_ctrl, rd_ctrl;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[31:CTRL_W];

    assign step         = unit_bytes(q.ctrl.width);
    assign port_mode    = q.ctrl.mode[1];
    // the port-side address never moves (R6)
    assign src_hold_eff = q.ctrl.src_hold | (port_mode & ~q.ctrl.to_port);
    assign dst_hold_eff = q.ctrl.dst_hold | (port_mode &  q.ctrl.to_port);
    assign cont_eff     = q.ctrl.cont & q.ctrl.block & (q.ctrl.mode != SRC_SOFT);
    assign demand_eff   = q.ctrl.demand & ~q.ctrl.block & ~q.ctrl.cont;
    assign single_mode  = ~q.ctrl.block & ~demand_eff;
    assign busy         = (q.st == ST_WAIT) || (q.st == ST_READ) ||
                          (q.st == ST_WRITE) || (q.st == ST_GAP);
    assign last_unit    = (q.cnt <= CNT_W'(step));

    always_comb begin
        if (q.ctrl.mode == SRC_SOFT)           go = 1'b1;
        else if (q.ctrl.block || demand_eff)   go = req_level;
        else                                   go = req_pend;
    end

    assign consume = (q.st == ST_WAIT) && go && single_mode;

    dma_req_sel u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (q.ctrl.mode),
        .active    (busy),
        .ext_req   (ext_req),
        .port0_req (uart0_req),
        .port1_req (uart1_req),
        .consume   (consume),
        .req_level (req_level),
        .req_pend  (req_pend)
    );

    dma_addr_step #(.AW(ADDR_W)) u_src_step (
        .cur   (q.src),
        .bytes (step),
        .dec   (q.ctrl.src_dec),
        .hold  (src_hold_eff),
        .nxt   (src_next)
    );

    dma_addr_step #(.AW(ADDR_W)) u_dst_step (
        .cur   (q.dst),
        .bytes (step),
        .dec   (q.ctrl.dst_dec),
        .hold  (dst_hold_eff),
        .nxt   (dst_next)
    );

    always_comb begin
        wr_ctrl        = dma_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        wr_ctrl.status = 1'b0;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: ;
            ST_WAIT: if (go) d.st = ST_READ;
            ST_READ: begin
                d.data = mem_rdata;
                d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                d.src = src_next;
                d.dst = dst_next;
                if (last_unit) begin
                    d.cnt = '0;
                    d.st  = ST_STOP;
                    d.irq = q.ctrl.irq_en;
                end else begin
                    d.cnt = q.cnt - CNT_W'(step);
                    if (q.ctrl.block) d.st = cont_eff ? ST_READ : ST_GAP;
                    else              d.st = ST_WAIT;
                end
            end
            ST_GAP:  d.st = ST_READ;
            ST_STOP: ;
            default: d.st = ST_IDLE;
        endcase

        // register writes take priority over the sequencer
        if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    d.ctrl = wr_ctrl;
                    if (!wr_ctrl.run) begin
                        d.st  = ST_IDLE;
                        d.irq = 1'b0;
                    end else if (q.st == ST_IDLE) begin
                        if (wr_ctrl.width == W_NONE || q.cnt == '0) begin
                            d.st  = ST_STOP;
                            d.irq = wr_ctrl.irq_en;
                        end else begin
                            d.st  = ST_WAIT;
                        end
                    end
                end
                OFS_SRC: d.src = reg_wdata[ADDR_W-1:0];
                OFS_DST: d.dst = reg_wdata[ADDR_W-1:0];
                default: d.cnt = reg_wdata[CNT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_ctrl        = q.ctrl;
        rd_ctrl.status = busy;
        case (reg_addr)
            OFS_CTRL: reg_rdata = 32'(rd_ctrl);
            OFS_SRC:  reg_rdata = 32'(q.src);
            OFS_DST:  reg_rdata = 32'(q.dst);
            default:  reg_rdata = 32'(q.cnt);
        endcase
    end

    assign mem_req   = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we    = (q.st == ST_WRITE);
    assign mem_addr  = (q.st == ST_WRITE) ? q.dst : q.src;
    assign mem_wdata = q.data;
    assign mem_size  = q.ctrl.width;
    assign irq       = q.irq;
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic             run_wr,
    input logic             mem_req,
    input logic             mem_we,
    input logic [1:0]       mem_size,
    input logic             irq,
    input logic             busy,
    input logic [CNT_W-1:0] cnt
);
    logic stop_wr;
    assign stop_wr = reg_we && (reg_addr == 2'd0) && !run_wr;

    p_idle_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_write_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !stop_wr) |=> (mem_req && mem_we));

    p_count_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reg_we) |=> (cnt <= $past(cnt)));

    p_irq_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stop_wr) |=> irq);

    p_irq_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    p_no_unused_width_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 2'd3));

    p_stop_write_idles_r14: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!busy && !irq && !mem_req));
endmodule

bind dma_channel dma_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .run_wr   (reg_wdata[0]),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_size (mem_size),
    .irq      (irq),
    .busy     (busy),
    .cnt      (q.cnt)
);

// File: tb/dma_channel_bench.sv
`timescale 1ns/1ps
module dma_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_req = 1'b0, uart0_req = 1'b0, uart1_req = 1'b0;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    int tests = 0, fails = 0, cyc = 0, acc_count = 0;
    int last_wr_cyc = -1, gap_min = 1000, gap_max = 0;

    typedef struct {
        bit          we;
        int unsigned addr;
        int unsigned size;
        logic [31:0] data;
    } acc_t;
    acc_t expq[$];

    logic [7:0] mem [0:4095];

    dma_channel u_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
        .uart0_req(uart0_req), .uart1_req(uart1_req), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] peek(input logic [31:0] a);
        int unsigned b;
        b = a & 32'hFFF;
        return {mem[(b+3) & 32'hFFF], mem[(b+2) & 32'hFFF],
                mem[(b+1) & 32'hFFF], mem[b]};
    endfunction

    function automatic logic [31:0] size_mask(input int unsigned sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference memory, access order checker and gap recorder
    always @(negedge clk) begin
        cyc++;
        mem_rdata = peek(mem_addr);
        if (rst_n && mem_req) begin
            acc_t e;
            acc_count++;
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected access: actual addr %h we %0d expected none",
                         mem_addr, mem_we);
            end else begin
                e = expq.pop_front();
                if (mem_we !== e.we || mem_addr !== e.addr || mem_size !== e.size[1:0] ||
                    (e.we && ((mem_wdata & size_mask(e.size)) !== (e.data & size_mask(e.size))))) begin
                    fails++;
                    $display("FAIL R7 access: actual we %0d addr %h size %0d data %h expected we %0d addr %h size %0d data %h",
                             mem_we, mem_addr, mem_size, mem_wdata, e.we, e.addr, e.size, e.data);
                end
            end
            if (mem_we) begin
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[(mem_addr + k) & 32'hFFF] = mem_wdata[8*k +: 8];
                last_wr_cyc = cyc;
            end else if (last_wr_cyc >= 0) begin
                if (cyc - last_wr_cyc < gap_min) gap_min = cyc - last_wr_cyc;
                if (cyc - last_wr_cyc > gap_max) gap_max = cyc - last_wr_cyc;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (!v[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) ext_req = 1'b1; else if (which == 2) uart0_req = 1'b1; else uart1_req = 1'b1;
        @(negedge clk);
        ext_req = 1'b0; uart0_req = 1'b0; uart1_req = 1'b0;
    endtask

    function automatic logic [31:0] cw(input int mode, input int width,
        input bit ddec, input bit sdec, input bit dfix, input bit sfix,
        input bit ien, input bit tou, input bit blk, input bit cont, input bit dem);
        return (32'(mode) << 2) | (32'(ddec) << 4) | (32'(sdec) << 5) |
               (32'(dfix) << 6) | (32'(sfix) << 7) | (32'(ien) << 8) |
               (32'(tou) << 9) | (32'(blk) << 10) | (32'(cont) << 11) |
               (32'(width) << 12) | (32'(dem) << 14);
    endfunction

    // behavioural prediction of the access sequence from the requirements
    task automatic plan(input int unsigned s0, input int unsigned d0, input int unsigned cnt,
                        input int w, input bit s_hold, input bit d_hold,
                        input bit s_dec, input bit d_dec);
        int unsigned s, d, left, stp;
        acc_t a;
        s = s0; d = d0; left = cnt; stp = 1 << w;
        while (left > 0) begin
            a.we = 0; a.addr = s; a.size = w; a.data = '0;
            expq.push_back(a);
            a.we = 1; a.addr = d; a.data = peek(s) & size_mask(w);
            expq.push_back(a);
            if (!s_hold) s = s_dec ? s - stp : s + stp;
            if (!d_hold) d = d_dec ? d - stp : d + stp;
            left = (left > stp) ? left - stp : 0;
        end
    endtask

    task automatic start(input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] n);
        wr(2'd0, 32'h0);
        wr(2'd1, s); wr(2'd2, d); wr(2'd3, n);
        last_wr_cyc = -1; gap_min = 1000; gap_max = 0;
        wr(2'd0, c | 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, c1, c2;
        int snap;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1 reset picture
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            check("R1", "register after reset", v, 32'h0);
        end
        check("R1", "irq after reset", 32'(irq), 32'h0);
        check("R1", "mem_req after reset", 32'(mem_req), 32'h0);

        // R2 register map
        wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, v); check("R2", "source readback", v, 32'hDEAD_BEEF);
        wr(2'd2, 32'h1234_5678); rd(2'd2, v); check("R2", "destination readback", v, 32'h1234_5678);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R2", "count is 24 bits", v, 32'h00FF_FFFF);
        wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, v); check("R2", "control stored bits", v, 32'h0000_7FFC);

        // software block word, continuous ignored in mode 0
        plan(32'h100, 32'h400, 16, 2, 0, 0, 0, 0);
        start(cw(0, 2, 0, 0, 0, 0, 1, 0, 1, 1, 0), 32'h100, 32'h400, 16);
        rd(2'd0, v); check("R11", "busy after run write", 32'(v[1]), 32'h1);
        idle_cycles(4);
        rd(2'd3, v); check("R11", "count shows progress", v, 32'd12);
        wait_idle();
        check("R12", "irq at end of busy", 32'(irq), 32'h1);
        check("R7", "all accesses seen", 32'(expq.size()), 32'h0);
        rd(2'd3, v); check("R3", "word count ends at zero", v, 32'h0);
        rd(2'd1, v); check("R4", "source incremented", v, 32'h110);
        rd(2'd2, v); check("R4", "destination incremented", v, 32'h410);
        check("R9", "block gap min in mode 0", 32'(gap_min), 32'd2);
        check("R9", "block gap max in mode 0", 32'(gap_max), 32'd2);
        idle_cycles(5);
        check("R12", "irq holds", 32'(irq), 32'h1);
        wr(2'd0, 32'h0);
        check("R12", "irq clears on run clear", 32'(irq), 32'h0);

        // byte, source decrements, destination hold beats decrement
        plan(32'h230, 32'h600, 5, 0, 0, 1, 1, 1);
        start(cw(0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 0), 32'h230, 32'h600, 5);
        wait_idle();
        check("R7", "byte accesses seen", 32'(expq.size()), 32'h0);
        rd(2'd1, v); check("R4", "source decremented", v, 32'h22B);
        rd(2'd2, v); check("R4", "hold wins over decrement", v, 32'h600);
        check("R12", "irq low when disabled", 32'(irq), 32'h0);

        // halfword with odd count
        plan(32'h300, 32'h700, 5, 1, 0, 0, 0, 0);
        start(cw(0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0), 32'h300, 32'h700, 5);
        wait_idle();
        rd(2'd3, v); check("R3", "halfword count stops at zero", v, 32'h0);
        rd(2'd1, v); check("R3", "three halfword units", v, 32'h306);
        check("R7", "halfword accesses seen", 32'(expq.size()), 32'h0);

        // single mode on the external line
        plan(32'h340, 32'h740, 12, 2, 0, 0, 0, 0);
        start(cw(1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0), 32'h340, 32'h740, 12);
        idle_cycles(6);
        rd(2'd3, v); check("R8", "no unit without request", v, 32'd12);
        pulse(2);
        idle_cycles(6);
        rd(2'd3, v); check("R5", "unselected line ignored", v, 32'd12);
        pulse(1);
        idle_cycles(8);
        rd(2'd3, v); check("R8", "one unit per edge", v, 32'd8);
        pulse(1); pulse(1);
        idle_cycles(12);
        rd(2'd3, v); check("R8", "edge during unit kept", v, 32'd0);
        check("R12", "irq after single mode", 32'(irq), 32'h1);

        // port 0, memory to port, continuous block
        plan(32'h380, 32'h7F0, 16, 2, 0, 1, 0, 0);
        start(cw(2, 2, 0, 0, 0, 0, 1, 1, 1, 1, 0), 32'h380, 32'h7F0, 16);
        uart0_req = 1'b1;
        wait_idle();
        uart0_req = 1'b0;
        rd(2'd2, v); check("R6", "port destination held", v, 32'h7F0);
        rd(2'd1, v); check("R4", "memory source moved", v, 32'h390);
        check("R9", "continuous gap min", 32'(gap_min), 32'd1);
        check("R9", "continuous gap max", 32'(gap_max), 32'd1);
        check("R7", "continuous accesses seen", 32'(expq.size()), 32'h0);

        // port 1, port to memory, demand
        plan(32'h3C0, 32'h800, 8, 0, 1, 0, 0, 0);
        start(cw(3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1), 32'h3C0, 32'h800, 8);
        @(negedge clk); uart1_req = 1'b1;
        idle_cycles(6);
        uart1_req = 1'b0;
        idle_cycles(3);
        rd(2'd3, c1);
        idle_cycles(10);
        rd(2'd3, c2);
        check("R10", "count frozen while request low", c2, c1);
        check("R10", "partial progress", 32'(c1 > 0 && c1 < 8), 32'h1);
        rd(2'd1, v); check("R6", "port source held", v, 32'h3C0);
        uart1_req = 1'b1;
        wait_idle();
        uart1_req = 1'b0;
        rd(2'd2, v); check("R10", "demand finishes", v, 32'h808);
        check("R7", "demand accesses seen", 32'(expq.size()), 32'h0);

        // width 3 and zero count
        snap = acc_count;
        start(cw(0, 3, 0, 0, 0, 0, 1, 0, 1, 0, 0), 32'h100, 32'h400, 8);
        rd(2'd0, v); check("R13", "width 3 not busy", 32'(v[1]), 32'h0);
        check("R13", "width 3 irq", 32'(irq), 32'h1);
        idle_cycles(8);
        check("R13", "width 3 no access", 32'(acc_count - snap), 32'h0);
        rd(2'd3, v); check("R13", "width 3 count kept", v, 32'd8);
        start(cw(0, 2, 0, 0, 0, 0, 1, 0, 1, 0, 0), 32'h100, 32'h400, 0);
        idle_cycles(4);
        check("R13", "zero count irq", 32'(irq), 32'h1);
        check("R13", "zero count no access", 32'(acc_count - snap), 32'h0);

        // abort in mid-transfer
        plan(32'h400, 32'h900, 64, 2, 0, 0, 0, 0);
        start(cw(0, 2, 0, 0, 0, 0, 1, 0, 1, 0, 0), 32'h400, 32'h900, 64);
        idle_cycles(7);
        wr(2'd0, 32'h0);
        expq.delete();
        rd(2'd0, v); check("R14", "abort drops busy", 32'(v[1]), 32'h0);
        check("R14", "abort drops irq", 32'(irq), 32'h0);
        snap = acc_count;
        idle_cycles(10);
        check("R14", "no access after abort", 32'(acc_count - snap), 32'h0);
        wr(2'd1, 32'h0); wr(2'd2, 32'h0); wr(2'd3, 32'h0);
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            check("R14", "zeroed register", v, 32'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule